// File: doc/BRIEF.md
# Port Access Handshake Pulse Generator

This block produces an active-low handshake strobe for a peripheral port. The processor reads or writes the port's data register. The strobe tells the attached device that this happened. The block takes the read select and the write select of that register, which are decoded elsewhere, and merges them into one access strobe. It passes that strobe through a short chain of registers and emits a low pulse only on the first cycle of each access.

Because the block reacts to the start of an access, its output stays bounded in two cases. An access stretched over many cycles, such as a processor held in a wait state, gives one pulse. So does a read-modify-write sequence whose cycles follow one another without a gap. The parameter `DELAY` sets how many clock cycles pass between the start of the access and the low cycle. A value of 1 gives the fast variant and a value of 2 gives the slower one. The output is a plain driven signal, high when idle.

Top module: `hs_pulse_gen`

## Requirements
- R1: While `rst` is high, `strobe_n` is high, even if an access select is active. Once `rst` has been sampled low, an access that ended while reset was still asserted produces no pulse.
- R2: A read select (`port_rd` = 1) held for one cycle, starting in cycle n, drives `strobe_n` low in cycle n+`DELAY` and in no other cycle.
- R3: A write select (`port_wr` = 1) held for one cycle, starting in cycle n, drives `strobe_n` low in cycle n+`DELAY` and in no other cycle.
- R4: An access held active for several consecutive cycles, starting in cycle n, gives exactly one low cycle, in cycle n+`DELAY`.
- R5: Every low pulse on `strobe_n` lasts exactly one clock cycle.
- R6: A read followed directly by writes in the next cycles, with no idle cycle between them, counts as one access and gives one pulse.
- R7: Accesses separated by at least one idle cycle each give their own pulse, `DELAY` cycles after each one begins.
- R8: A cycle with both `port_rd` and `port_wr` high counts as a single access and gives one pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| port_rd | input | 1 | Read select of the port data register, active high |
| port_wr | input | 1 | Write select of the port data register, active high |
| strobe_n | output | 1 | Handshake strobe, active low, one cycle wide |

## Verification
Both the fast (`DELAY`=1) and the slow (`DELAY`=2) variants receive the same sequences, and each output is recorded as a sixteen-cycle mask of low cycles. Single reads, single writes and simultaneous selects show whether each select source reaches the strobe, and whether the delay equals the parameter. Long held accesses and gap-free read-modify-write runs separate edge detection from level following. Accesses spaced one idle cycle apart show that a short gap still re-arms the detector. A pattern with access during reset shows whether the chain is cleared.

// File: rtl/hs_pulse_pkg.sv
package hs_pulse_pkg;

    // One cycle's view of the register select lines.
    typedef struct packed {
        logic rd;
        logic wr;
    } acc_sel_t;

    // Chain taps fed to the edge picker.
    typedef struct packed {
        logic newer;
        logic older;
    } chain_tap_t;

    localparam int unsigned MIN_DELAY = 1;

    function automatic logic sel_active(input acc_sel_t s);
        return s.rd | s.wr;
    endfunction

    function automatic logic start_seen(input chain_tap_t t);
        return t.newer & ~t.older;
    endfunction

endpackage

// File: rtl/hs_access_merge.sv
module hs_access_merge
    import hs_pulse_pkg::*;
(
    input  acc_sel_t sel,
    output logic     access
);

    always_comb begin
        access = sel_active(sel);
    end

endmodule

// File: rtl/hs_delay_chain.sv
module hs_delay_chain
    import hs_pulse_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    output chain_tap_t tap
);

    logic [DEPTH-1:0] stage;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stage[i] <= 1'b0;
                    else     stage[i] <= din;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) stage[i] <= 1'b0;
                    else     stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    always_comb begin
        tap.newer = stage[DEPTH-2];
        tap.older = stage[DEPTH-1];
    end

endmodule

// File: rtl/hs_edge_pick.sv
module hs_edge_pick
    import hs_pulse_pkg::*;
(
    input  chain_tap_t tap,
    output logic       pulse_n
);

    always_comb begin
        pulse_n = ~start_seen(tap);
    end

endmodule

// File: rtl/hs_pulse_gen.sv
module hs_pulse_gen
    import hs_pulse_pkg::*;
#(
    parameter int unsigned DELAY = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic port_rd,
    input  logic port_wr,
    output logic strobe_n
);

    localparam int unsigned EFF_DELAY   = (DELAY < MIN_DELAY) ? MIN_DELAY : DELAY;
    localparam int unsigned CHAIN_DEPTH = EFF_DELAY + 1;

    acc_sel_t   sel;
    logic       access;
    chain_tap_t tap;

    always_comb begin
        sel.rd = port_rd;
        sel.wr = port_wr;
    end

    hs_access_merge u_merge (
        .sel    (sel),
        .access (access)
    );

    hs_delay_chain #(
        .DEPTH (CHAIN_DEPTH)
    ) u_chain (
        .clk (clk),
        .rst (rst),
        .din (access),
        .tap (tap)
    );

    hs_edge_pick u_pick (
        .tap     (tap),
        .pulse_n (strobe_n)
    );

endmodule

// File: rtl/hs_pulse_gen_chk.sv
module hs_pulse_gen_chk #(
    parameter int unsigned DELAY = 1
) (
    input logic clk,
    input logic rst,
    input logic port_rd,
    input logic port_wr,
    input logic strobe_n
);

    localparam int unsigned D    = (DELAY < 1) ? 1 : DELAY;
    localparam int unsigned WARM = D + 2;

    logic [7:0] since_rst;
    logic       warm;
    logic       acc;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (!warm)          since_rst <= since_rst + 8'd1;
    end

    always_comb begin
        warm = (since_rst >= 8'(WARM));
        acc  = port_rd | port_wr;
    end

    // R1: output is idle on the first cycle after reset is released
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> strobe_n);

    // R5: a low cycle is always followed by a high one
    p_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |=> strobe_n);

    // R4: a low cycle only ever marks the first cycle of an access
    p_cause_r4: assert property (@(posedge clk) disable iff (rst)
        (warm && !strobe_n) |-> ($past(acc, D) && !$past(acc, D + 1)));

    // R2: the start of an access always yields a low cycle DELAY later
    p_start_gives_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(acc, D) && !$past(acc, D + 1)) |-> !strobe_n);

endmodule

bind hs_pulse_gen hs_pulse_gen_chk #(.DELAY(DELAY)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .port_rd  (port_rd),
    .port_wr  (port_wr),
    .strobe_n (strobe_n)
);

// File: tb/hs_pulse_gen_bench.sv
module hs_pulse_gen_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic port_rd = 1'b0;
    logic port_wr = 1'b0;
    logic strobe_fast_n;
    logic strobe_slow_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    hs_pulse_gen #(.DELAY(1)) u_hs_pulse_gen (
        .clk (clk), .rst (rst), .port_rd (port_rd), .port_wr (port_wr),
        .strobe_n (strobe_fast_n)
    );

    hs_pulse_gen #(.DELAY(2)) u_hs_pulse_gen_slow (
        .clk (clk), .rst (rst), .port_rd (port_rd), .port_wr (port_wr),
        .strobe_n (strobe_slow_n)
    );

    task automatic check_mask(string req, string what, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%04h expected=%04h", req, what, act, exp);
        end
    endtask

    // Drives 16 cycles of select bits; bit i is active in cycle i.
    // Records which cycles show each strobe low.
    task automatic run_pattern(string req, logic [15:0] rd_bits, logic [15:0] wr_bits,
                               logic [15:0] exp_fast, logic [15:0] exp_slow);
        logic [15:0] low_fast = '0;
        logic [15:0] low_slow = '0;
        for (int i = 0; i < 16; i++) begin
            @(posedge clk);
            #1;
            port_rd = rd_bits[i];
            port_wr = wr_bits[i];
            @(negedge clk);
            low_fast[i] = ~strobe_fast_n;
            low_slow[i] = ~strobe_slow_n;
        end
        port_rd = 1'b0;
        port_wr = 1'b0;
        check_mask(req, "fast variant", low_fast, exp_fast);
        check_mask(req, "slow variant", low_slow, exp_slow);
    endtask

    // R1: reset holds the strobe high and clears a pending access
    task automatic test_reset();
        logic [7:0] low_fast = '0;
        logic [7:0] low_slow = '0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk);
            #1;
            rst     = (i < 4);
            port_rd = (i >= 1 && i < 4);
            @(negedge clk);
            low_fast[i] = ~strobe_fast_n;
            low_slow[i] = ~strobe_slow_n;
        end
        port_rd = 1'b0;
        check_mask("R1", "fast reset/idle", {8'h00, low_fast}, 16'h0000);
        check_mask("R1", "slow reset/idle", {8'h00, low_slow}, 16'h0000);
    endtask

    task automatic test_single_read();   // R2
        run_pattern("R2", 16'h0004, 16'h0000, 16'h0008, 16'h0010);
    endtask

    task automatic test_single_write();  // R3
        run_pattern("R3", 16'h0000, 16'h0004, 16'h0008, 16'h0010);
    endtask

    task automatic test_held();          // R4 and R5
        run_pattern("R4/R5 held access", 16'h00FC, 16'h0000, 16'h0008, 16'h0010);
        run_pattern("R4 held write", 16'h0000, 16'h3FC0, 16'h0080, 16'h0100);
    endtask

    task automatic test_rmw();           // R6
        run_pattern("R6", 16'h0004, 16'h0018, 16'h0008, 16'h0010);
    endtask

    task automatic test_spaced();        // R7
        run_pattern("R7 gap", 16'h0004, 16'h0010, 16'h0028, 16'h0050);
        run_pattern("R7 alternate", 16'h0154, 16'h0000, 16'h02A8, 16'h0550);
    endtask

    task automatic test_both();          // R8
        run_pattern("R8", 16'h0004, 16'h0004, 16'h0008, 16'h0010);
    endtask

    initial begin
        test_reset();
        test_single_read();
        test_single_write();
        test_held();
        test_rmw();
        test_spaced();
        test_both();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule